// File: doc/BRIEF.md
# Idle-Cycle Dual-Bank DMA Engine

This block moves stereo sample pairs between a set of peripheral channels and two independent data memory banks, called X and Y. It never asks the processor core for a memory slot in the normal case. A transfer is issued only into a bank that the core leaves unused in that cycle. Each channel selects its bank on its own: always X, always Y, or X and Y in turn on successive pairs. Each channel walks a circular address window given by a base and a length.

When the core keeps a bank busy for a long time, for example in a tight inner loop, a starvation counter runs down. When no bank-free transfer exists and the counter has reached zero, the engine raises a core stall for a single cycle. It spends that cycle on the channel that has been waiting longest, whatever the bank state.

In the default set-up, eleven channels are allocated: six output, four input and one for a parallel control port. The twelfth channel is spare. Output channels read memory and input channels write it; each channel's direction is set by a configuration bit.

Top module: `dma_bank_stealer`

## Requirements
- R1: A channel is acknowledged only in a cycle where its request is high. At most one channel is acknowledged per cycle. Every acknowledge coincides with exactly one of `x_en`/`y_en`, and the write strobe of that port equals the channel's `cfg_dir` bit (1 = write into memory).
- R2: The 2-bit channel mode selects the bank: 0 = X, 1 = Y, 2 = alternate, 3 = X. In alternate mode a channel targets X first. It then flips to the other bank after each of its completed transfers.
- R3: A channel's address is its base plus an offset. The offset starts at 0 and rises by one per transfer. It returns to 0 after `len` transfers, so with `len` 3 the addresses run base, base+1, base+2, base. With a length of 0 or 1 the address stays at base.
- R4: Without a stall, no transfer goes to a bank whose busy input is high. A channel whose bank is busy waits, while a channel whose bank is free proceeds in the same cycle.
- R5: Among channels that can proceed, the first one at or above a rotating pointer wins, and the search wraps to lower numbers. After any grant the pointer moves to the winner plus one, modulo the channel count, and it starts at 0.
- R6: The starvation counter loads `starve_reload` in every cycle with a transfer or with no pending request, and otherwise counts down to 0. When `starve_reload` is R, a request blocked from its first pending cycle on is forced in that request's (R+1)th cycle.
- R7: A forced transfer raises `core_stall` for that one cycle only and ignores both busy inputs. It serves the pending channel with the longest unbroken wait since its last grant; on a tie the lower number wins.
- R8: One cycle after a read transfer, `pair_rvalid` is one-hot for that channel and `pair_rdata` carries the word returned by the bank that was addressed.
- R9: On a write transfer, `x_wdata`/`y_wdata` carry the granted channel's `chan_wdata` word.
- R10: After reset there is no acknowledge, memory enable or stall. All offsets are 0, every alternating channel starts on X, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req | input | NCH | Per-channel transfer request |
| chan_ack | output | NCH | Per-channel transfer done, one-hot |
| cfg_dir | input | NCH | 1 = channel writes memory, 0 = reads |
| cfg_mode | input | 2*NCH | Per-channel bank mode, 2 bits each |
| cfg_base | input | AW*NCH | Per-channel window base |
| cfg_len | input | AW*NCH | Per-channel window length |
| chan_wdata | input | DW*NCH | Per-channel pair to write |
| starve_reload | input | TW | Starvation counter load value |
| x_busy | input | 1 | Core uses bank X this cycle |
| y_busy | input | 1 | Core uses bank Y this cycle |
| x_en | output | 1 | Bank X access strobe |
| x_we | output | 1 | Bank X write enable |
| x_addr | output | AW | Bank X address |
| x_wdata | output | DW | Bank X write data |
| x_rdata | input | DW | Bank X read data, one cycle latency |
| y_en | output | 1 | Bank Y access strobe |
| y_we | output | 1 | Bank Y write enable |
| y_addr | output | AW | Bank Y address |
| y_wdata | output | DW | Bank Y write data |
| y_rdata | input | DW | Bank Y read data, one cycle latency |
| pair_rdata | output | DW | Pair returned to a reading channel |
| pair_rvalid | output | NCH | One-hot channel owning `pair_rdata` |
| core_stall | output | 1 | Core must yield this cycle |

## Verification
Two functions can fall in the same cycle: the round-robin search over channels whose bank is free, and the starvation path that grabs a cycle for the oldest waiter. These collide when the counter has reached zero. The bench provokes this by holding both banks busy while two channels queue at different times. The expected forced cycle and the expected winner are computed from the load value and the arrival order. The winner is the earlier arrival, not the lower number, and the stall must fall in the next cycle. The counter's reload after the forced grant is judged by a low stall one cycle later, while a second channel is still waiting.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  typedef enum logic [1:0] {
    MODE_X   = 2'd0,
    MODE_Y   = 2'd1,
    MODE_ALT = 2'd2,
    MODE_RSV = 2'd3
  } bank_mode_e;

  // 1 when the channel's next pair goes to bank Y
  function automatic logic target_is_y(input logic [1:0] mode, input logic tog);
    case (bank_mode_e'(mode))
      MODE_Y:   return 1'b1;
      MODE_ALT: return tog;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_state.sv
module dma_chan_state #(
  parameter int AW   = 8,
  parameter int AGEW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          grant,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] addr,
  output logic          want_y,
  output logic [AGEW-1:0] age
);
  import dma_steal_pkg::*;

  logic [AW-1:0] off_q;
  logic          tog_q;

  function automatic logic [AW-1:0] next_off(input logic [AW-1:0] off,
                                             input logic [AW-1:0] n);
    if (n <= AW'(1))          return '0;
    if (off >= n - AW'(1))    return '0;
    return off + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      tog_q <= 1'b0;
      age   <= '0;
    end else begin
      if (grant) begin
        off_q <= next_off(off_q, len);
        if (bank_mode_e'(mode) == MODE_ALT) tog_q <= ~tog_q;
      end
      if (!req || grant)  age <= '0;
      else if (age != '1) age <= age + AGEW'(1);
    end
  end

  assign addr   = base + off_q;
  assign want_y = target_is_y(mode, tog_q);

endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
  parameter int N  = 12,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] idx,
  output logic          hit
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!hit && elig[j]) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/dma_oldest_pick.sv
module dma_oldest_pick #(
  parameter int N    = 12,
  parameter int AGEW = 6,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]      pend,
  input  logic [N*AGEW-1:0] ages,
  output logic [IW-1:0]     idx,
  output logic              hit
);
  logic [AGEW-1:0] best;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!hit || ages[i*AGEW +: AGEW] > best)) begin
        hit  = 1'b1;
        idx  = IW'(i);
        best = ages[i*AGEW +: AGEW];
      end
    end
  end
endmodule

// File: rtl/dma_starve_timer.sv
module dma_starve_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] reload,
  input  logic          pending,
  input  logic          xfer,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '1;
    else if (xfer || !pending) cnt_q <= reload;
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dma_bank_stealer.sv
module dma_bank_stealer #(
  parameter int NCH  = 12,
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int TW   = 8,
  parameter int AGEW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_req,
  output logic [NCH-1:0]    chan_ack,
  input  logic [NCH-1:0]    cfg_dir,
  input  logic [2*NCH-1:0]  cfg_mode,
  input  logic [AW*NCH-1:0] cfg_base,
  input  logic [AW*NCH-1:0] cfg_len,
  input  logic [DW*NCH-1:0] chan_wdata,
  input  logic [TW-1:0]     starve_reload,
  input  logic              x_busy,
  input  logic              y_busy,
  output logic              x_en,
  output logic              x_we,
  output logic [AW-1:0]     x_addr,
  output logic [DW-1:0]     x_wdata,
  input  logic [DW-1:0]     x_rdata,
  output logic              y_en,
  output logic              y_we,
  output logic [AW-1:0]     y_addr,
  output logic [DW-1:0]     y_wdata,
  input  logic [DW-1:0]     y_rdata,
  output logic [DW-1:0]     pair_rdata,
  output logic [NCH-1:0]    pair_rvalid,
  output logic              core_stall
);
  localparam int IW = $clog2(NCH);

  // named internal events
  logic [NCH-1:0]      want_y;
  logic [NCH-1:0]      elig;
  logic [AW-1:0]       ch_addr [NCH];
  logic [NCH*AGEW-1:0] age_flat;
  logic [IW-1:0]       rr_ptr_q;
  logic [IW-1:0]       rr_idx, old_idx, grant_idx;
  logic                rr_hit, old_hit, any_pend, expired, force_hit, grant_vld;
  logic [NCH-1:0]      grant_vec;
  logic                sel_y, sel_we;
  logic [AW-1:0]       sel_addr;
  logic [DW-1:0]       sel_wdata;
  logic                rsel_y_q;
  logic [NCH-1:0]      rvalid_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dma_chan_state #(.AW(AW), .AGEW(AGEW)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (chan_req[i]),
      .grant  (grant_vec[i]),
      .mode   (cfg_mode[2*i +: 2]),
      .base   (cfg_base[AW*i +: AW]),
      .len    (cfg_len[AW*i +: AW]),
      .addr   (ch_addr[i]),
      .want_y (want_y[i]),
      .age    (age_flat[AGEW*i +: AGEW])
    );
    assign elig[i]      = chan_req[i] && (want_y[i] ? !y_busy : !x_busy);
    assign grant_vec[i] = grant_vld && (grant_idx == IW'(i));
  end

  dma_rr_pick #(.N(NCH)) u_rr (
    .elig (elig),
    .ptr  (rr_ptr_q),
    .idx  (rr_idx),
    .hit  (rr_hit)
  );

  dma_oldest_pick #(.N(NCH), .AGEW(AGEW)) u_old (
    .pend (chan_req),
    .ages (age_flat),
    .idx  (old_idx),
    .hit  (old_hit)
  );

  assign any_pend = |chan_req;

  dma_starve_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (starve_reload),
    .pending (any_pend),
    .xfer    (grant_vld),
    .expired (expired)
  );

  assign force_hit = expired && old_hit && !rr_hit;
  assign grant_vld = rr_hit || force_hit;
  assign grant_idx = rr_hit ? rr_idx : old_idx;

  always_comb begin
    sel_y     = 1'b0;
    sel_we    = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant_vec[i]) begin
        sel_y     = want_y[i];
        sel_we    = cfg_dir[i];
        sel_addr  = ch_addr[i];
        sel_wdata = chan_wdata[DW*i +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr_q <= '0;
      rsel_y_q <= 1'b0;
      rvalid_q <= '0;
    end else begin
      if (grant_vld)
        rr_ptr_q <= (grant_idx == IW'(NCH - 1)) ? '0 : grant_idx + IW'(1);
      rvalid_q <= grant_vec & ~cfg_dir;
      if (grant_vld) rsel_y_q <= sel_y;
    end
  end

  assign chan_ack    = grant_vec;
  assign core_stall  = force_hit;
  assign x_en        = grant_vld && !sel_y;
  assign y_en        = grant_vld && sel_y;
  assign x_we        = x_en && sel_we;
  assign y_we        = y_en && sel_we;
  assign x_addr      = sel_addr;
  assign y_addr      = sel_addr;
  assign x_wdata     = sel_wdata;
  assign y_wdata     = sel_wdata;
  assign pair_rvalid = rvalid_q;
  assign pair_rdata  = rsel_y_q ? y_rdata : x_rdata;

endmodule

// File: rtl/dma_bank_stealer_chk.sv
module dma_bank_stealer_chk #(
  parameter int NCH = 12,
  parameter int TW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_req,
  input logic [NCH-1:0] chan_ack,
  input logic [NCH-1:0] cfg_dir,
  input logic           x_busy,
  input logic           y_busy,
  input logic           x_en,
  input logic           y_en,
  input logic           core_stall,
  input logic [NCH-1:0] pair_rvalid,
  input logic [TW-1:0]  starve_reload,
  input logic           rr_hit
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_ack)); // R1
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_ack & ~chan_req) == '0); // R1
  AST_ACK_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_ack) == (x_en ^ y_en) && !(x_en && y_en)); // R1
  AST_X_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (x_en && !core_stall) |-> !x_busy); // R4
  AST_Y_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (y_en && !core_stall) |-> !y_busy); // R4
  AST_STALL_ONLY_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> !rr_hit); // R6
  AST_STALL_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> (|chan_ack)); // R7
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && starve_reload != '0) |=> !core_stall); // R7
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_ack & ~cfg_dir)) |=> $onehot(pair_rvalid)); // R8
endmodule

bind dma_bank_stealer dma_bank_stealer_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chan_req      (chan_req),
  .chan_ack      (chan_ack),
  .cfg_dir       (cfg_dir),
  .x_busy        (x_busy),
  .y_busy        (y_busy),
  .x_en          (x_en),
  .y_en          (y_en),
  .core_stall    (core_stall),
  .pair_rvalid   (pair_rvalid),
  .starve_reload (starve_reload),
  .rr_hit        (rr_hit)
);

// File: tb/dma_bank_stealer_test.sv
module dma_bank_stealer_test;
  localparam int PERIOD = 10;
  localparam int NCH = 12, AW = 8, DW = 32, TW = 8, AGEW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] chan_req, chan_ack, cfg_dir, pair_rvalid;
  logic [2*NCH-1:0] cfg_mode;
  logic [AW*NCH-1:0] cfg_base, cfg_len;
  logic [DW*NCH-1:0] chan_wdata;
  logic [TW-1:0] starve_reload;
  logic x_busy, y_busy, x_en, x_we, y_en, y_we, core_stall;
  logic [AW-1:0] x_addr, y_addr;
  logic [DW-1:0] x_wdata, y_wdata, x_rdata, y_rdata, pair_rdata;
  logic [DW-1:0] xm [2**AW];
  logic [DW-1:0] ym [2**AW];
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_bank_stealer #(.NCH(NCH), .AW(AW), .DW(DW), .TW(TW), .AGEW(AGEW)) uut (.*);

  always @(posedge clk) begin
    if (x_en) begin
      if (x_we) xm[x_addr] <= x_wdata; else x_rdata <= xm[x_addr];
    end
    if (y_en) begin
      if (y_we) ym[y_addr] <= y_wdata; else y_rdata <= ym[y_addr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_ch(input int ch, input logic [1:0] m, input logic d,
                        input logic [AW-1:0] b, input logic [AW-1:0] l);
    cfg_mode[2*ch +: 2]  = m;
    cfg_dir[ch]          = d;
    cfg_base[AW*ch +: AW] = b;
    cfg_len[AW*ch +: AW]  = l;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    chan_req = '0; x_busy = 1'b0; y_busy = 1'b0; starve_reload = 8'd200;
    for (int i = 0; i < NCH; i++) begin
      set_ch(i, 2'd0, 1'b0, AW'(16*i), AW'(16));
      chan_wdata[DW*i +: DW] = 32'hA5A5_0000 + 32'(i);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // cycle helper: drive after falling edge, sample 1 time unit later
  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R10 ack", 32'(chan_ack), 0);
    chk("R10 en", {30'd0, x_en, y_en}, 0);
    chk("R10 stall", 32'(core_stall), 0);
    set_ch(0, 2'd2, 1'b0, 8'h40, 8'd8);
    chan_req[0] = 1'b1; chan_req[5] = 1'b1;
    #1;
    chk("R10 ptr0 winner", 32'(chan_ack), 32'h1);
    chk("R10 alt starts X", {30'd0, x_en, y_en}, 32'h2);
    chk("R10 offset0", 32'(x_addr), 32'h40);
  endtask

  task automatic t_wrap();
    logic [AW-1:0] exp_a [4] = '{8'h10, 8'h11, 8'h12, 8'h10};
    do_reset();
    set_ch(2, 2'd0, 1'b0, 8'h10, 8'd3);
    chan_req[2] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R3 wrap addr", 32'(x_addr), 32'(exp_a[k]));
      chk("R1 ack ch2", 32'(chan_ack), 32'h4);
      next_cycle();
    end
    set_ch(3, 2'd0, 1'b0, 8'h30, 8'd1);
    chan_req = 12'h008;
    for (int k = 0; k < 2; k++) begin
      #1; chk("R3 len1 stays", 32'(x_addr), 32'h30);
      next_cycle();
    end
    chan_req = '0;
  endtask

  task automatic t_modes();
    do_reset();
    set_ch(5, 2'd2, 1'b0, 8'h20, 8'd8);
    chan_req[5] = 1'b1;
    #1; chk("R2 alt X", {30'd0, x_en, y_en}, 32'h2); chk("R2 addr", 32'(x_addr), 32'h20);
    next_cycle();
    #1; chk("R2 alt Y", {30'd0, x_en, y_en}, 32'h1); chk("R2 addr", 32'(y_addr), 32'h21);
    next_cycle();
    #1; chk("R2 alt X again", {30'd0, x_en, y_en}, 32'h2);
    next_cycle();
    chan_req = '0;
    set_ch(6, 2'd1, 1'b0, 8'h60, 8'd8);
    set_ch(7, 2'd3, 1'b0, 8'h70, 8'd8);
    chan_req[6] = 1'b1;
    #1; chk("R2 mode1 Y", {30'd0, x_en, y_en}, 32'h1);
    next_cycle();
    chan_req = 12'h080;
    #1; chk("R2 mode3 X", {30'd0, x_en, y_en}, 32'h2);
    next_cycle();
    chan_req = '0;
  endtask

  task automatic t_busy();
    do_reset();
    set_ch(1, 2'd1, 1'b0, 8'h10, 8'd8);
    x_busy = 1'b1;
    chan_req = 12'h003;
    #1;
    chk("R4 free bank wins", 32'(chan_ack), 32'h2);
    chk("R4 no stall", 32'(core_stall), 0);
    next_cycle();
    chan_req = 12'h001;
    #1; chk("R4 busy waits", 32'(chan_ack), 0);
    chk("R4 no x_en", 32'(x_en), 0);
    next_cycle();
    x_busy = 1'b0;
    #1; chk("R4 proceeds when free", 32'(chan_ack), 32'h1);
    next_cycle();
    chan_req = '0;
  endtask

  task automatic t_rr();
    logic [31:0] order [4] = '{32'h1, 32'h2, 32'h4, 32'h1};
    do_reset();
    chan_req = 12'h007;
    for (int k = 0; k < 4; k++) begin
      #1; chk("R5 rotation", 32'(chan_ack), order[k]);
      next_cycle();
    end
    chan_req = '0;
  endtask

  task automatic t_data();
    do_reset();
    set_ch(4, 2'd1, 1'b1, 8'h55, 8'd4);
    set_ch(8, 2'd1, 1'b0, 8'h55, 8'd4);
    chan_wdata[DW*4 +: DW] = 32'hCAFE_0004;
    chan_req = 12'h010;
    #1;
    chk("R9 write strobe", {30'd0, y_en, y_we}, 32'h3);
    chk("R9 write data", y_wdata, 32'hCAFE_0004);
    chk("R1 we follows dir", 32'(x_we), 0);
    next_cycle();
    chan_req = 12'h100;
    #1; chk("R1 read no we", {30'd0, y_en, y_we}, 32'h2);
    next_cycle();
    chan_req = '0;
    #1;
    chk("R8 rvalid", 32'(pair_rvalid), 32'h100);
    chk("R8 rdata", pair_rdata, 32'hCAFE_0004);
    next_cycle();
    #1; chk("R8 rvalid drops", 32'(pair_rvalid), 0);
  endtask

  task automatic t_starve();
    do_reset();
    starve_reload = 8'd4;
    x_busy = 1'b1; y_busy = 1'b1;
    next_cycle();
    chan_req[3] = 1'b1;
    #1; chk("R6 wait c0", {31'd0, core_stall}, 0);
    next_cycle();
    chan_req[1] = 1'b1;
    for (int k = 1; k < 4; k++) begin
      #1;
      chk("R6 no early stall", {31'd0, core_stall}, 0);
      chk("R6 no early ack", 32'(chan_ack), 0);
      next_cycle();
    end
    #1;
    chk("R6 stall on expiry", {31'd0, core_stall}, 1);
    chk("R7 oldest served", 32'(chan_ack), 32'h8);
    chk("R7 ignores busy", 32'(x_en), 1);
    next_cycle();
    chan_req[3] = 1'b0;
    #1;
    chk("R7 single stall", {31'd0, core_stall}, 0);
    chk("R6 reload after force", 32'(chan_ack), 0);
    next_cycle();
    chan_req = '0; x_busy = 1'b0; y_busy = 1'b0;
  endtask

  initial begin
    cfg_mode = '0; cfg_dir = '0; cfg_base = '0; cfg_len = '0; chan_wdata = '0;
    chan_req = '0; x_busy = 0; y_busy = 0; starve_reload = 8'd200;
    t_reset();
    t_wrap();
    t_modes();
    t_busy();
    t_rr();
    t_data();
    t_starve();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule